// File: doc/BRIEF.md
# Low-Power Sleep and Wake-Up Sequencer

This block decides when a bus controller may drop into its low-power state, and how it comes back out of it. The host asks for sleep by setting either of two request bits. Each bit belongs to one operating mode, and the two have the same effect. The request is granted only when the receive line shows no activity, no interrupt is pending and no earlier wake-up is still unacknowledged. Once the request is granted, the block reports itself asleep. It keeps the oscillator and the clock output running for a further fifteen bit-time ticks, so that a host clocked from that output can reach its own low-power mode first. After that it stops the oscillator.

There are three ways to wake up: a dominant (low) level on the receive line, a high level on the external wake pin, or the host clearing the sleep request. Any of them restarts the oscillator, raises a sticky wake-up interrupt and clears both request bits. If one of them arrives during the hold-off, the oscillator is never stopped and the block goes straight back to awake. After a restart, the clock output stays off until the oscillator reports that it is stable.

The block runs on an always-on clock. The receive line, the wake pin and the stability flag reach it through reset-safe synchronisers. The bit tick comes from the protocol engine and is a single-cycle pulse in this clock domain. The block has no data path, so every pin is a plain level or pulse and none uses a handshake.

Top module: `pwr_nap_ctrl`

## Requirements
- R1: After reset the block is awake: osc_en=1, clkout_en=1, sleeping=0, wake_irq=0, and both request bits read 0.
- R2: Writing 1 to either request bit (sleep_a or sleep_b) on its own, with the bus idle and nothing pending, makes sleeping=1 while osc_en and clkout_en stay 1.
- R3: A request made while rx_line is low, while irq_pending=1, or while wake_irq=1 is held off. The block stays awake and the request bit stays set. Sleep is granted once all three conditions have cleared.
- R4: After sleep is granted, osc_en and clkout_en stay 1 through the first 14 bit_tick pulses. Both drop to 0 after the 15th, while sleeping stays 1.
- R5: While asleep, a low level on rx_line restarts the oscillator: osc_en=1, clkout_en=0, sleeping=0, wake_irq=1.
- R6: While asleep, a high level on wake_pin wakes the block in the same way as R5.
- R7: While asleep, the host writing 0 to the request bit that was set (so that neither bit remains set) wakes the block in the same way as R5.
- R8: After a restart, clkout_en stays 0 while osc_stable is low. It returns to 1 only after osc_stable goes high.
- R9: A wake-up condition during the hold-off returns the block straight to awake: osc_en never drops, and wake_irq=1.
- R10: Every wake-up clears both request bits in the same cycle that wake_irq is set.
- R11: wake_irq stays set until a wake_irq_ack pulse clears it. When a new wake-up and an ack arrive in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_a_we | input | 1 | Write strobe for request bit A |
| sleep_a_wd | input | 1 | Write data for request bit A |
| sleep_b_we | input | 1 | Write strobe for request bit B |
| sleep_b_wd | input | 1 | Write data for request bit B |
| wake_irq_ack | input | 1 | Pulse that clears the wake-up interrupt |
| irq_pending | input | 1 | Some controller interrupt is pending |
| rx_line | input | 1 | Receive line, low is dominant (activity) |
| wake_pin | input | 1 | External wake-up request, active high |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| osc_stable | input | 1 | Restarted oscillator is stable |
| osc_en | output | 1 | Oscillator enable |
| clkout_en | output | 1 | Clock output enable |
| sleeping | output | 1 | Sleep status (hold-off or asleep) |
| wake_irq | output | 1 | Sticky wake-up interrupt |
| sleep_a | output | 1 | Read-back of request bit A |
| sleep_b | output | 1 | Read-back of request bit B |

## Verification
The bench goes after the length of the hold-off. It checks that the oscillator still runs after the 14th tick and stops after the 15th, so a counter that is off by one in either direction shows up as an oscillator that stops early or late. It gives each of the three wake sources a turn, and a wake source left out of the wake condition would leave the block stuck asleep. It sends a wake-up during the hold-off, where a design that passes through the stopped state would drop osc_en for a while. It also holds osc_stable low after a restart, which catches a clock output that comes back too early. It makes a request while the bus is busy, while an interrupt is pending and while a wake-up is unacknowledged, to catch a grant that skips one of those guards or a request bit that gets lost.

// File: rtl/pwr_nap_pkg.sv
package pwr_nap_pkg;

  typedef enum logic [1:0] {
    NAP_AWAKE   = 2'd0,
    NAP_HOLDOFF = 2'd1,
    NAP_ASLEEP  = 2'd2,
    NAP_RESTART = 2'd3
  } nap_state_e;

  localparam int unsigned NAP_HOLD_BITS_DEF   = 15;
  localparam int unsigned NAP_SYNC_STAGES_DEF = 2;

endpackage

// File: rtl/nap_sync.sv
module nap_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES < 2) begin : g_single
      logic r_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RST_VAL;
        else        r_q <= d;
      end
      assign q = r_q;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
      assign q = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/nap_req_regs.sv
module nap_req_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic a_we,
  input  logic a_wd,
  input  logic b_we,
  input  logic b_wd,
  input  logic ack,
  input  logic wake_evt,
  output logic bit_a,
  output logic bit_b,
  output logic req,
  output logic irq
);
  // a wake-up clears the request bits and beats any write in that cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_a <= 1'b0;
      bit_b <= 1'b0;
    end else if (wake_evt) begin
      bit_a <= 1'b0;
      bit_b <= 1'b0;
    end else begin
      if (a_we) bit_a <= a_wd;
      if (b_we) bit_b <= b_wd;
    end
  end

  // a new wake event beats an acknowledge in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        irq <= 1'b0;
    else if (wake_evt) irq <= 1'b1;
    else if (ack)      irq <= 1'b0;
  end

  assign req = bit_a | bit_b;
endmodule

// File: rtl/nap_holdoff.sv
module nap_holdoff #(
  parameter int unsigned HOLD_BITS = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int unsigned CW = (HOLD_BITS < 2) ? 1 : $clog2(HOLD_BITS);
  localparam logic [CW-1:0] LAST = CW'(HOLD_BITS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (tick)    cnt_q <= cnt_q + 1'b1;
  end

  assign done = run && tick && (cnt_q == LAST);
endmodule

// File: rtl/nap_settle.sv
module nap_settle #(
  parameter bit          FROM_PIN = 1'b1,
  parameter int unsigned CYCLES   = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic pin_s,
  output logic ok
);
  generate
    if (FROM_PIN) begin : g_pin
      logic ok_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ok_q <= 1'b0;
        else        ok_q <= run & pin_s;
      end
      assign ok = ok_q;
    end else begin : g_count
      localparam int unsigned SW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
      logic [SW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (!run)               cnt_q <= '0;
        else if (cnt_q != SW'(CYCLES)) cnt_q <= cnt_q + 1'b1;
      end
      assign ok = run && (cnt_q == SW'(CYCLES));
    end
  endgenerate
endmodule

// File: rtl/nap_fsm.sv
module nap_fsm
  import pwr_nap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       busy,
  input  logic       irq_block,
  input  logic       pin_wake,
  input  logic       hold_done,
  input  logic       stable_ok,
  output nap_state_e state,
  output logic       wake_evt,
  output logic       hold_run,
  output logic       restart_run,
  output logic       osc_on,
  output logic       clk_on,
  output logic       asleep_flag
);
  nap_state_e st_q, st_d;
  logic       wake_cond;

  assign wake_cond = busy | pin_wake | ~req;

  always_comb begin
    st_d     = st_q;
    wake_evt = 1'b0;
    unique case (st_q)
      NAP_AWAKE: begin
        if (req && !busy && !irq_block) st_d = NAP_HOLDOFF;
      end
      NAP_HOLDOFF: begin
        if (wake_cond) begin
          st_d     = NAP_AWAKE;
          wake_evt = 1'b1;
        end else if (hold_done) begin
          st_d = NAP_ASLEEP;
        end
      end
      NAP_ASLEEP: begin
        if (wake_cond) begin
          st_d     = NAP_RESTART;
          wake_evt = 1'b1;
        end
      end
      NAP_RESTART: begin
        if (stable_ok) st_d = NAP_AWAKE;
      end
      default: st_d = NAP_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= NAP_AWAKE;
    else        st_q <= st_d;
  end

  assign state       = st_q;
  assign hold_run    = (st_q == NAP_HOLDOFF);
  assign restart_run = (st_q == NAP_RESTART);
  assign osc_on      = (st_q != NAP_ASLEEP);
  assign clk_on      = (st_q == NAP_AWAKE) || (st_q == NAP_HOLDOFF);
  assign asleep_flag = (st_q == NAP_HOLDOFF) || (st_q == NAP_ASLEEP);
endmodule

// File: rtl/pwr_nap_ctrl.sv
module pwr_nap_ctrl
  import pwr_nap_pkg::*;
#(
  parameter int unsigned HOLD_BITS     = NAP_HOLD_BITS_DEF,
  parameter int unsigned SYNC_STAGES   = NAP_SYNC_STAGES_DEF,
  parameter bit          STABLE_PIN    = 1'b1,
  parameter int unsigned STABLE_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_a_we,
  input  logic sleep_a_wd,
  input  logic sleep_b_we,
  input  logic sleep_b_wd,
  input  logic wake_irq_ack,
  input  logic irq_pending,
  input  logic rx_line,
  input  logic wake_pin,
  input  logic bit_tick,
  input  logic osc_stable,
  output logic osc_en,
  output logic clkout_en,
  output logic sleeping,
  output logic wake_irq,
  output logic sleep_a,
  output logic sleep_b
);
  logic       rx_s, pin_s, stab_s;
  logic       req, wake_evt, hold_run, restart_run, hold_done, stable_ok;
  nap_state_e state;

  nap_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_rx (
    .clk(clk), .rst_n(rst_n), .d(rx_line), .q(rx_s));
  nap_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_pin (
    .clk(clk), .rst_n(rst_n), .d(wake_pin), .q(pin_s));
  nap_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_stab (
    .clk(clk), .rst_n(rst_n), .d(osc_stable), .q(stab_s));

  nap_req_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .a_we(sleep_a_we), .a_wd(sleep_a_wd),
    .b_we(sleep_b_we), .b_wd(sleep_b_wd),
    .ack(wake_irq_ack), .wake_evt(wake_evt),
    .bit_a(sleep_a), .bit_b(sleep_b), .req(req), .irq(wake_irq));

  nap_holdoff #(.HOLD_BITS(HOLD_BITS)) u_hold (
    .clk(clk), .rst_n(rst_n), .run(hold_run), .tick(bit_tick), .done(hold_done));

  nap_settle #(.FROM_PIN(STABLE_PIN), .CYCLES(STABLE_CYCLES)) u_settle (
    .clk(clk), .rst_n(rst_n), .run(restart_run), .pin_s(stab_s), .ok(stable_ok));

  nap_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req(req), .busy(~rx_s), .irq_block(irq_pending | wake_irq),
    .pin_wake(pin_s), .hold_done(hold_done), .stable_ok(stable_ok),
    .state(state), .wake_evt(wake_evt),
    .hold_run(hold_run), .restart_run(restart_run),
    .osc_on(osc_en), .clk_on(clkout_en), .asleep_flag(sleeping));
endmodule

// File: rtl/pwr_nap_ctrl_chk.sv
module pwr_nap_ctrl_chk #(
  parameter int unsigned HOLD_BITS = 15
) (
  input logic clk,
  input logic rst_n,
  input logic osc_en,
  input logic clkout_en,
  input logic sleeping,
  input logic wake_irq,
  input logic wake_irq_ack,
  input logic sleep_a,
  input logic sleep_b,
  input logic irq_pending,
  input logic bit_tick,
  input logic rx_s,
  input logic stable_ok
);
  localparam int unsigned CW = $clog2(HOLD_BITS + 2);
  logic [CW-1:0] tick_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   tick_cnt <= '0;
    else if (!(sleeping && osc_en)) tick_cnt <= '0;
    else if (bit_tick)            tick_cnt <= tick_cnt + 1'b1;
  end

  assert_osc_off_only_asleep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> sleeping);

  assert_holdoff_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_en) |-> (tick_cnt == CW'(HOLD_BITS)));

  assert_clkout_needs_osc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clkout_en |-> osc_en);

  assert_clkout_after_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clkout_en) |-> $past(stable_ok));

  assert_grant_guarded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleeping) |-> ($past(sleep_a | sleep_b) && !$past(irq_pending)
                         && $past(rx_s) && !$past(wake_irq)));

  assert_wake_clears_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_irq) |-> (!sleep_a && !sleep_b));

  assert_irq_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_irq && !wake_irq_ack) |=> wake_irq);

  assert_holdoff_wake_keeps_osc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sleeping) && $past(osc_en)) |-> (osc_en && clkout_en && wake_irq));
endmodule

bind pwr_nap_ctrl pwr_nap_ctrl_chk #(.HOLD_BITS(HOLD_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .clkout_en(clkout_en),
  .sleeping(sleeping), .wake_irq(wake_irq), .wake_irq_ack(wake_irq_ack),
  .sleep_a(sleep_a), .sleep_b(sleep_b), .irq_pending(irq_pending),
  .bit_tick(bit_tick), .rx_s(rx_s), .stable_ok(stable_ok));

// File: tb/pwr_nap_ctrl_tb.sv
module pwr_nap_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_a_we = 0, sleep_a_wd = 0, sleep_b_we = 0, sleep_b_wd = 0;
  logic wake_irq_ack = 0, irq_pending = 0, rx_line = 1, wake_pin = 0;
  logic bit_tick = 0, osc_stable = 1;
  logic osc_en, clkout_en, sleeping, wake_irq, sleep_a, sleep_b;

  int checks = 0;
  int failures = 0;
  bit osc_dropped = 0;

  typedef struct {
    logic [5:0] v;   // osc_en, clkout_en, sleeping, wake_irq, sleep_a, sleep_b
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  pwr_nap_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .sleep_a_we(sleep_a_we), .sleep_a_wd(sleep_a_wd),
    .sleep_b_we(sleep_b_we), .sleep_b_wd(sleep_b_wd),
    .wake_irq_ack(wake_irq_ack), .irq_pending(irq_pending),
    .rx_line(rx_line), .wake_pin(wake_pin), .bit_tick(bit_tick),
    .osc_stable(osc_stable), .osc_en(osc_en), .clkout_en(clkout_en),
    .sleeping(sleeping), .wake_irq(wake_irq), .sleep_a(sleep_a), .sleep_b(sleep_b));

  // monitor: compares queued expectations a quarter period after each rising edge
  always @(posedge clk) begin
    #5;
    if (rst_n && !osc_en) osc_dropped = 1'b1;
    if (sb_q.size() != 0) begin
      exp_t e;
      logic [5:0] act;
      e   = sb_q.pop_front();
      act = {osc_en, clkout_en, sleeping, wake_irq, sleep_a, sleep_b};
      checks++;
      if (act !== e.v) begin
        failures++;
        $display("FAIL %s: osc/clk/slp/irq/a/b actual=%b expected=%b", e.tag, act, e.v);
      end
    end
  end

  task automatic expect_out(input logic [5:0] v, input string tag);
    exp_t e;
    e.v = v;
    e.tag = tag;
    sb_q.push_back(e);
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) bit_tick = 1'b1;
      @(negedge clk) bit_tick = 1'b0;
    end
  endtask

  task automatic wr_a(input logic d);
    @(negedge clk) begin sleep_a_we = 1'b1; sleep_a_wd = d; end
    @(negedge clk) sleep_a_we = 1'b0;
  endtask

  task automatic wr_b(input logic d);
    @(negedge clk) begin sleep_b_we = 1'b1; sleep_b_wd = d; end
    @(negedge clk) sleep_b_we = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk) wake_irq_ack = 1'b1;
    @(negedge clk) wake_irq_ack = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    settle(3);
    rst_n = 1'b1;
    settle(2);
    expect_out(6'b110000, "R1 reset state");

    // R2: bit A alone requests sleep; clocks keep running in hold-off
    wr_a(1'b1);
    settle(5);
    expect_out(6'b111010, "R2 granted via bit A");

    // R4: 14 ticks keep the oscillator, the 15th stops it
    ticks(14);
    expect_out(6'b111010, "R4 still running after 14 ticks");
    ticks(1);
    settle(1);
    expect_out(6'b001010, "R4 stopped after 15th tick");
    osc_stable = 1'b0;

    // R5 / R10: bus activity wakes, clears the request, raises irq
    settle(3);
    rx_line = 1'b0;
    settle(6);
    expect_out(6'b100100, "R5 R10 rx wake to restart");
    settle(10);
    expect_out(6'b100100, "R8 clock output held while unstable");
    osc_stable = 1'b1;
    settle(6);
    expect_out(6'b110100, "R8 clock output back after stable");
    rx_line = 1'b1;
    settle(4);

    // R3 / R11: unacknowledged wake-up blocks a new request (bit B)
    wr_b(1'b1);
    settle(8);
    expect_out(6'b110101, "R3 R11 held off by unacked irq");
    ack();
    settle(4);
    expect_out(6'b111001, "R11 ack clears, R2 granted via bit B");
    ticks(15);
    settle(1);
    expect_out(6'b001001, "R4 asleep via bit B");
    osc_stable = 1'b0;

    // R6: wake pin
    settle(3);
    wake_pin = 1'b1;
    settle(6);
    expect_out(6'b100100, "R6 R10 wake pin to restart");
    wake_pin = 1'b0;
    osc_stable = 1'b1;
    settle(6);
    expect_out(6'b110100, "R8 awake after pin wake");
    ack();
    settle(2);

    // R3: pending interrupt holds the request off
    irq_pending = 1'b1;
    wr_a(1'b1);
    settle(8);
    expect_out(6'b110010, "R3 held off by irq_pending");
    irq_pending = 1'b0;
    settle(4);
    expect_out(6'b111010, "R3 granted after irq_pending clears");
    ticks(15);
    settle(1);
    expect_out(6'b001010, "R4 asleep again");
    osc_stable = 1'b0;

    // R7: host clears the request
    settle(3);
    wr_a(1'b0);
    settle(4);
    expect_out(6'b100100, "R7 host clear wakes");
    osc_stable = 1'b1;
    settle(6);
    expect_out(6'b110100, "R8 awake after host wake");
    ack();
    settle(2);

    // R3: bus activity holds the request off
    rx_line = 1'b0;
    settle(4);
    wr_a(1'b1);
    settle(8);
    expect_out(6'b110010, "R3 held off by bus activity");
    rx_line = 1'b1;
    settle(6);
    expect_out(6'b111010, "R3 granted after bus idle");

    // R9: activity during hold-off never stops the oscillator
    osc_dropped = 1'b0;
    ticks(5);
    rx_line = 1'b0;
    settle(6);
    expect_out(6'b110100, "R9 hold-off wake returns awake");
    checks++;
    if (osc_dropped) begin
      failures++;
      $display("FAIL R9: osc dropped actual=1 expected=0");
    end
    rx_line = 1'b1;
    settle(4);
    ack();
    settle(2);
    expect_out(6'b110000, "R11 ack clears irq");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule